// File: doc/BRIEF.md
# Configuration Bitstream Loader

This block sits on a host register bus and moves a configuration image, delivered as 32-bit words, to downstream configurable devices over a byte-wide valid/ready stream. Software disables the loader, loads the image length in bytes, enables it, and then writes the image through a data window. The writes can come from the CPU directly, or from an external DMA engine that the block paces with a burst request. Each word enters a FIFO and is then split into bytes, most significant byte first.

The loader counts every byte the target accepts. A completion interrupt is raised once the sent count equals the programmed length and the target reports done, or as soon as an error flag is set. One control write with the enable bit clear stops the loader, flushes the FIFO and the byte shifter, and acknowledges the interrupt. The same control register drives a level reset to the targets, which software pulses by setting the bit and then writing zero.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset the control register reads 0, the FIFO-used register reads 0, the FIFO-size register reads DEPTH*4 (64 by default), and irq, dma_req, tgt_valid and tgt_reset are all low.
- R2: The control register at byte offset 0x40 is read/write, and only bits 2:0 are kept. Bit 0 enables the loader, bit 1 drives tgt_reset directly, and bit 2 selects DMA-request mode.
- R3: The total byte count at offset 0x50 takes writes only while bit 0 of the control register is 0. A write made while the loader is enabled leaves the value unchanged.
- R4: A write to offset 0x3000 while the loader is enabled and the FIFO is not full pushes the word into the FIFO. Offset 0x4C reads the number of words held in the FIFO, which excludes the word in the byte shifter.
- R5: Each word goes out as four bytes on tgt_data, starting with bits 31:24. A byte transfers on a clock where tgt_valid and tgt_ready are both high. While tgt_ready is low, tgt_valid and tgt_data hold steady.
- R6: The current byte count at offset 0x54 goes up by one for each byte transferred. It clears to 0 on the control write that changes bit 0 from 0 to 1.
- R7: While the loader is enabled, irq rises once the current byte count equals the total byte count and tgt_done is high. Status bit 18 at offset 0x44 shows tgt_done.
- R8: A data-window write while the FIFO is full or the loader is disabled drops the word and sets status bit 1, the overflow error. The FIFO-used count does not change. If the loader is enabled, irq rises.
- R9: If the total byte count is not a multiple of 4 when the loader is enabled, status bit 2 is set and irq rises. Enabling the loader clears all error bits (status bits 15:1) and then sets bit 2 if this condition holds.
- R10: A control write with bit 0 clear, including a write of all zeros, drops irq. It also empties the FIFO and drops tgt_valid. Error bits are kept until the next enable. Status bit 0 shows irq.
- R11: dma_req is high when the loader is enabled, control bit 2 is set, and the FIFO has at least DEPTH/2 free words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata one clock later |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Completion/error interrupt, level |
| dma_req | output | 1 | Burst request to the external DMA engine |
| tgt_reset | output | 1 | Reset to the configuration targets |
| tgt_data | output | 8 | Byte to the target |
| tgt_valid | output | 1 | tgt_data is valid |
| tgt_ready | input | 1 | Target accepts the byte |
| tgt_done | input | 1 | Target reports that configuration is done |

## Verification
The byte-splitting path is driven with a table of words, each paired with its own pattern of target stalls. Words with alternating byte values, a single set bit at each end and all ones show whether byte order and data holding under back-pressure are correct. Each table entry also runs a full enable/length/done cycle, so it tells apart a completion raised by the count alone from one that needs tgt_done. Directed cases fill the FIFO past full, write data while disabled, use a length that is not a multiple of 4, write the length while enabled, and step the FIFO level across the half-depth point in DMA mode.

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader #(
  parameter int DEPTH = 16,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          dma_req,
  output logic          tgt_reset,
  output logic [7:0]    tgt_data,
  output logic          tgt_valid,
  input  logic          tgt_ready,
  input  logic          tgt_done
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] A_CTL  = AW'(16'h0040);
  localparam logic [AW-1:0] A_STAT = AW'(16'h0044);
  localparam logic [AW-1:0] A_SIZE = AW'(16'h0048);
  localparam logic [AW-1:0] A_USED = AW'(16'h004C);
  localparam logic [AW-1:0] A_TOT  = AW'(16'h0050);
  localparam logic [AW-1:0] A_CUR  = AW'(16'h0054);
  localparam logic [AW-1:0] A_DATA = AW'(16'h3000);

  logic [2:0]    ctl;
  logic [31:0]   total, cur;
  logic [15:1]   err;
  logic          irq_q;
  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [31:0]   shreg;
  logic [1:0]    idx;
  logic          loaded;

  wire en     = ctl[0];
  wire ctl_wr = bus_wr && (bus_addr == A_CTL);
  wire tot_wr = bus_wr && (bus_addr == A_TOT);
  wire dat_wr = bus_wr && (bus_addr == A_DATA);
  wire start  = ctl_wr && bus_wdata[0] && !en;
  wire stop   = ctl_wr && !bus_wdata[0];
  wire hs     = tgt_valid && tgt_ready;
  wire last   = hs && (idx == 2'd3);
  wire pop    = en && (count != '0) && (!loaded || last);
  wire push   = dat_wr && en && (count != FULL);
  wire drop   = dat_wr && !push;

  assign tgt_valid = en && loaded;
  assign tgt_data  = shreg[31:24];
  assign tgt_reset = ctl[1];
  assign irq       = irq_q;
  assign dma_req   = en && ctl[2] && ((FULL - count) >= HALF);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl <= '0;
    else if (ctl_wr) ctl <= bus_wdata[2:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) total <= '0;
    else if (tot_wr && !en) total <= bus_wdata;

  always_ff @(posedge clk)
    if (push) mem[wp] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (stop) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0; idx <= '0; loaded <= 1'b0;
    end else if (stop) begin
      idx <= '0; loaded <= 1'b0;
    end else if (pop) begin
      shreg <= mem[rp]; idx <= '0; loaded <= 1'b1;
    end else if (hs) begin
      shreg <= shreg << 8;
      idx   <= idx + 2'd1;
      if (idx == 2'd3) loaded <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cur <= '0;
    else if (start) cur <= '0;
    else if (hs) cur <= cur + 32'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err <= '0;
    else if (start) err <= {13'd0, |total[1:0], 1'b0};
    else if (drop) err[1] <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else if (stop) irq_q <= 1'b0;
    else if (en && (((cur == total) && tgt_done) || (|err))) irq_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd)
      case (bus_addr)
        A_CTL:   bus_rdata <= {29'd0, ctl};
        A_STAT:  bus_rdata <= {13'd0, tgt_done, 2'b00, err, irq_q};
        A_SIZE:  bus_rdata <= 32'(DEPTH * 4);
        A_USED:  bus_rdata <= 32'(count);
        A_TOT:   bus_rdata <= total;
        A_CUR:   bus_rdata <= cur;
        default: bus_rdata <= '0;
      endcase

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && !tgt_ready && !ctl_wr |=> tgt_valid && $stable(tgt_data));
  p_cur_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hs && !ctl_wr |=> $stable(cur));
  p_total_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en && tot_wr && !ctl_wr |=> $stable(total));
  p_drop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && !en && !ctl_wr |=> count == '0);
  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !irq && !tgt_valid);
endmodule

// File: tb/cfg_stream_loader_test.sv
module cfg_stream_loader_test;
  localparam int DEPTH = 16;
  localparam logic [15:0] A_CTL = 16'h0040, A_STAT = 16'h0044, A_SIZE = 16'h0048,
                          A_USED = 16'h004C, A_TOT = 16'h0050, A_CUR = 16'h0054,
                          A_DATA = 16'h3000;
  // [35:32] stall mask (bit k stalls byte k), [31:0] word
  localparam logic [35:0] VEC [6] = '{36'h0_A1B2C3D4, 36'h5_00FF00FF, 36'hA_12345678,
                                      36'hF_80000001, 36'h0_FFFFFFFF, 36'h3_DEADBEEF};

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, dma_req, tgt_reset, tgt_valid, tgt_ready = 0, tgt_done = 0;
  logic [7:0] tgt_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_stream_loader uut (.clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .irq, .dma_req, .tgt_reset, .tgt_data, .tgt_valid, .tgt_ready, .tgt_done);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic take_byte(input bit stall, output logic [7:0] b);
    int guard = 0;
    tgt_ready = 0;
    if (stall) @(negedge clk);
    while (!tgt_valid && guard < 100) begin @(negedge clk); guard++; end
    b = tgt_data;
    tgt_ready = 1;
    @(negedge clk);
    tgt_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 dma_req", {31'd0, dma_req}, 0);
    chk("R1 tgt_valid", {31'd0, tgt_valid}, 0);
    chk("R1 tgt_reset", {31'd0, tgt_reset}, 0);
    rd(A_CTL, v);  chk("R1 ctl", v, 0);
    rd(A_USED, v); chk("R1 used", v, 0);
    rd(A_SIZE, v); chk("R1 size", v, DEPTH * 4);

    // Table: byte order, stalls, counting and completion
    foreach (VEC[i]) begin
      wr(A_CTL, 0);
      wr(A_TOT, 4);
      tgt_done = 0;
      wr(A_CTL, 1);
      rd(A_CUR, v); chk("R6 cur cleared on enable", v, 0);
      wr(A_DATA, VEC[i][31:0]);
      for (int k = 0; k < 4; k++) begin
        take_byte(VEC[i][32+k], b);
        chk("R5 byte order", {24'd0, b}, {24'd0, VEC[i][31-8*k -: 8]});
      end
      @(negedge clk);
      chk("R7 no irq before done", {31'd0, irq}, 0);
      rd(A_CUR, v); chk("R6 cur after word", v, 4);
      tgt_done = 1;
      @(negedge clk); @(negedge clk);
      chk("R7 irq on done", {31'd0, irq}, 1);
      rd(A_STAT, v); chk("R7 status done bit", {31'd0, v[18]}, 1);
    end

    // R10 clear
    wr(A_CTL, 0);
    chk("R10 irq cleared", {31'd0, irq}, 0);
    rd(A_STAT, v); chk("R10 status irq bit", {31'd0, v[0]}, 0);
    tgt_done = 0;

    // R2 control and target reset
    wr(A_CTL, 2);
    chk("R2 tgt_reset high", {31'd0, tgt_reset}, 1);
    rd(A_CTL, v); chk("R2 ctl readback", v, 2);
    wr(A_CTL, 32'hFFFF_FFF6);
    rd(A_CTL, v); chk("R2 ctl width", v, 6);
    wr(A_CTL, 0);
    chk("R2 tgt_reset low", {31'd0, tgt_reset}, 0);

    // R8 write while disabled
    wr(A_DATA, 32'h1111_2222);
    rd(A_STAT, v); chk("R8 overflow when disabled", {31'd0, v[1]}, 1);
    rd(A_USED, v); chk("R8 disabled write dropped", v, 0);
    chk("R8 no irq when disabled", {31'd0, irq}, 0);

    // R3 total locked while enabled; R9 error clear on enable
    wr(A_TOT, 8);
    wr(A_CTL, 1);
    rd(A_STAT, v); chk("R9 errors cleared by enable", {16'd0, v[15:1], 1'b0}, 0);
    wr(A_TOT, 12);
    rd(A_TOT, v); chk("R3 total ignored while enabled", v, 8);

    // R4/R8 fill past full (target stalled)
    for (int k = 0; k < DEPTH + 1; k++) wr(A_DATA, 32'(k));
    rd(A_USED, v); chk("R4 used when full", v, DEPTH);
    wr(A_DATA, 32'hBAD0_BAD0);
    rd(A_USED, v); chk("R8 full write dropped", v, DEPTH);
    rd(A_STAT, v); chk("R8 overflow bit", {31'd0, v[1]}, 1);
    chk("R8 irq on overflow", {31'd0, irq}, 1);
    take_byte(0, b); chk("R4 first word reaches target", {24'd0, b}, 0);
    wr(A_CTL, 0);
    chk("R10 valid dropped", {31'd0, tgt_valid}, 0);
    rd(A_USED, v); chk("R10 fifo flushed", v, 0);
    rd(A_STAT, v); chk("R10 errors kept", {31'd0, v[1]}, 1);

    // R9 misaligned length
    wr(A_TOT, 6);
    wr(A_CTL, 1);
    @(negedge clk);
    rd(A_STAT, v); chk("R9 length error bit", {31'd0, v[2]}, 1);
    chk("R9 irq on length error", {31'd0, irq}, 1);
    wr(A_CTL, 0);

    // R11 DMA request
    wr(A_TOT, 64);
    wr(A_CTL, 1);
    chk("R11 no request without mode bit", {31'd0, dma_req}, 0);
    wr(A_CTL, 0);
    wr(A_CTL, 5);
    chk("R11 request when empty", {31'd0, dma_req}, 1);
    for (int k = 0; k < DEPTH / 2 + 1; k++) wr(A_DATA, 32'(k));
    chk("R11 request at half free", {31'd0, dma_req}, 1);
    wr(A_DATA, 32'h55);
    chk("R11 request drops below half", {31'd0, dma_req}, 0);
    wr(A_CTL, 0);
    chk("R11 request off when disabled", {31'd0, dma_req}, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule